// File: doc/BRIEF.md
# Line-State Pulse Link with Keepalive

This block carries the logic level of a local two-wire serial bus (data and clock) to a peer over a one-way pulse link. It also rebuilds the peer's levels from a matching incoming link. The outgoing side sends a short message each time the local levels change. While nothing changes, it repeats the current levels at a fixed interval as a keepalive. A message is a sequence of single-cycle-group pulses on a positive and a negative rail. Both rails rest low between messages.

The incoming side decodes each message and checks its framing. A valid level update sets the levels that the block asks the local bus drivers to produce. Silence on the incoming link for longer than a timeout counts as link loss. So do fault notices from the peer and a local stuck-bus flag. Any of these makes the block release the local bus and tell the peer. Driving resumes only when fresh levels arrive and both buses are quiet, meaning data and clock are both high.

Top module: `line_state_link`

## Requirements
- R1: Out of reset, tx_p and tx_n are low and drv_en is low. The first message sent is a level update carrying the current local levels.
- R2: A message is six pulse slots. Slot one is a pulse on tx_p and slot two is a pulse on tx_n. Then come four payload bits, most significant first: type[1], type[0], data level, clock level. A 1 is sent as a tx_p pulse and a 0 as a tx_n pulse. Each pulse is high for PULSE_CYC cycles and is followed by GAP_CYC low cycles. tx_p and tx_n are never high together.
- R3: The type codes are 00 for a level update, 01 for a stuck-bus notice and 10 for a not-driving notice. Code 11 is not valid.
- R4: Any change of {loc_sda, loc_scl} causes a level update carrying the new levels.
- R5: Level changes that occur while a message is being sent cause exactly one further level update. It starts right after the current message and carries the latest levels.
- R6: After REFRESH_CYC cycles with no message sent, a level update with the unchanged levels is sent again. No such update is sent earlier.
- R7: While drv_en is high, a valid received level update sets drv_sda and drv_scl to its data and clock bits.
- R8: A received message is discarded if any of these holds:
  - the rails start in the wrong order;
  - both rails rise together;
  - the type code is 11;
  - the gap between pulses exceeds GAP_LIMIT cycles.

  A discarded message changes no output and does not restart the silence timeout.
- R9: If no valid message arrives for RX_TMO_CYC cycles, drv_en falls and one not-driving notice is sent.
- R10: A received stuck-bus or not-driving notice makes drv_en fall. Its payload levels are not applied.
- R11: A rising edge of stuck_det sends a stuck-bus notice carrying the local levels, and makes drv_en fall.
- R12: drv_en rises only when all of the following hold:
  - a valid level update has been received since the last drop;
  - that update reports both levels high;
  - both local levels are high;
  - stuck_det is low;
  - the link is not in timeout.
- R13: While drv_en is low, drv_sda and drv_scl are both 1, meaning released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_sda | input | 1 | Synchronized local data level |
| loc_scl | input | 1 | Synchronized local clock level |
| stuck_det | input | 1 | Local stuck-bus flag from an external timer |
| rx_p | input | 1 | Incoming positive pulse rail |
| rx_n | input | 1 | Incoming negative pulse rail |
| tx_p | output | 1 | Outgoing positive pulse rail |
| tx_n | output | 1 | Outgoing negative pulse rail |
| drv_en | output | 1 | Local bus driving is allowed |
| drv_sda | output | 1 | Data level to drive (1 = release) |
| drv_scl | output | 1 | Clock level to drive (1 = release) |

## Verification
The assertions assume that all inputs are synchronous to clk. They also assume that an incoming pulse stays high for at least one sampled cycle, so that each pulse yields exactly one rising edge. The bench drives every input on the falling edge. It holds each incoming pulse for PULSE_CYC cycles and leaves more than GAP_LIMIT quiet cycles after every malformed message. As a result, a broken message can never merge with the valid message that follows it.

// File: rtl/lsl_pkg.sv
package lsl_pkg;

  typedef enum logic [1:0] {
    MSG_STATE = 2'b00,
    MSG_STUCK = 2'b01,
    MSG_NODRV = 2'b10,
    MSG_BAD   = 2'b11
  } msg_e;

  localparam int unsigned SLOTS = 6;

  // payload word: {type, data level, clock level}
  function automatic logic [3:0] pack_word(msg_e kind, logic [1:0] lvl);
    return {kind, lvl};
  endfunction

  // rail used by a slot: 1 = positive rail, 0 = negative rail
  function automatic logic slot_rail(logic [2:0] slot, logic [3:0] word);
    case (slot)
      3'd0:    return 1'b1;
      3'd1:    return 1'b0;
      3'd2:    return word[3];
      3'd3:    return word[2];
      3'd4:    return word[1];
      default: return word[0];
    endcase
  endfunction

endpackage

// File: rtl/lsl_tx.sv
module lsl_tx
  import lsl_pkg::*;
#(
  parameter int unsigned PULSE_CYC   = 9,
  parameter int unsigned GAP_CYC     = 9,
  parameter int unsigned REFRESH_CYC = 287500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] st_in,
  input  logic       stuck_req,
  input  logic       nodrv_req,
  output logic       tx_p,
  output logic       tx_n,
  output logic [1:0] st_q
);

  localparam int unsigned SLOT_CYC = PULSE_CYC + GAP_CYC;
  localparam int unsigned CW = $clog2(SLOT_CYC + 1);
  localparam int unsigned RW = $clog2(REFRESH_CYC + 1);
  localparam logic [CW-1:0] PULSE_L   = CW'(PULSE_CYC);
  localparam logic [CW-1:0] SLOT_LAST = CW'(SLOT_CYC - 1);
  localparam logic [RW-1:0] RF_LAST   = RW'(REFRESH_CYC - 1);
  localparam logic [2:0]    SLOT_END  = 3'(SLOTS - 1);

  logic          busy, pend_st, pend_stk, pend_nd;
  logic [2:0]    slot;
  logic [CW-1:0] cyc;
  logic [3:0]    word;
  logic [RW-1:0] rf_cnt;

  // named events
  logic chg_evt, start_evt, rf_evt, any_pend, rail, pulse_on;
  msg_e sel;

  always_comb begin
    chg_evt   = (st_in != st_q);
    any_pend  = pend_st || pend_stk || pend_nd;
    start_evt = !busy && any_pend;
    rf_evt    = !busy && !any_pend && (rf_cnt == RF_LAST);
    if (pend_stk)     sel = MSG_STUCK;
    else if (pend_nd) sel = MSG_NODRV;
    else              sel = MSG_STATE;
    rail     = slot_rail(slot, word);
    pulse_on = busy && (cyc < PULSE_L);
    tx_p     = pulse_on && rail;
    tx_n     = pulse_on && !rail;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= 2'b11;
      pend_st  <= 1'b1;
      pend_stk <= 1'b0;
      pend_nd  <= 1'b0;
      busy     <= 1'b0;
      slot     <= '0;
      cyc      <= '0;
      word     <= '0;
      rf_cnt   <= '0;
    end else begin
      st_q <= st_in;
      if (start_evt) begin
        busy <= 1'b1;
        slot <= '0;
        cyc  <= '0;
        word <= pack_word(sel, st_q);
        if (sel == MSG_STUCK)      pend_stk <= 1'b0;
        else if (sel == MSG_NODRV) pend_nd  <= 1'b0;
        else                       pend_st  <= 1'b0;
      end else if (busy) begin
        if (cyc == SLOT_LAST) begin
          cyc <= '0;
          if (slot == SLOT_END) busy <= 1'b0;
          else                  slot <= slot + 3'd1;
        end else begin
          cyc <= cyc + 1'b1;
        end
      end
      if (busy || any_pend || rf_evt) rf_cnt <= '0;
      else                            rf_cnt <= rf_cnt + 1'b1;
      if (chg_evt || rf_evt) pend_st  <= 1'b1;
      if (stuck_req)         pend_stk <= 1'b1;
      if (nodrv_req)         pend_nd  <= 1'b1;
    end
  end

  p_rails_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_p && tx_n));
  p_start_positive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> tx_p);
  p_queue_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && chg_evt) |=> pend_st);

endmodule

// File: rtl/lsl_rx.sv
module lsl_rx
  import lsl_pkg::*;
#(
  parameter int unsigned GAP_LIMIT  = 64,
  parameter int unsigned RX_TMO_CYC = 1150000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_p,
  input  logic       rx_n,
  output logic       frm_ok,
  output msg_e       frm_type,
  output logic [1:0] frm_st,
  output logic       lost,
  output logic       lost_evt
);

  localparam int unsigned GW = $clog2(GAP_LIMIT + 1);
  localparam int unsigned TW = $clog2(RX_TMO_CYC + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_LIMIT - 1);
  localparam logic [TW-1:0] TMO_LAST = TW'(RX_TMO_CYC - 1);
  localparam logic [2:0]    IDX_END  = 3'(SLOTS - 1);

  logic          rp_q, rn_q;
  logic [2:0]    idx;
  logic [2:0]    sh;
  logic [GW-1:0] gap_cnt;
  logic [TW-1:0] sil_cnt;
  logic [3:0]    frm_word;

  // named events
  logic rise_p, rise_n, any_rise, both_rise, done_evt, good_evt;
  logic [3:0] new_word;

  always_comb begin
    rise_p    = rx_p && !rp_q;
    rise_n    = rx_n && !rn_q;
    any_rise  = rise_p || rise_n;
    both_rise = rise_p && rise_n;
    done_evt  = any_rise && !both_rise && (idx == IDX_END);
    new_word  = {sh, rise_p};
    good_evt  = done_evt && (new_word[3:2] != MSG_BAD);
    frm_type  = msg_e'(frm_word[3:2]);
    frm_st    = frm_word[1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp_q     <= 1'b0;
      rn_q     <= 1'b0;
      idx      <= '0;
      sh       <= '0;
      gap_cnt  <= '0;
      sil_cnt  <= '0;
      frm_word <= '0;
      frm_ok   <= 1'b0;
      lost     <= 1'b0;
      lost_evt <= 1'b0;
    end else begin
      rp_q     <= rx_p;
      rn_q     <= rx_n;
      frm_ok   <= good_evt;
      lost_evt <= 1'b0;
      if (good_evt) frm_word <= new_word;
      if (any_rise) begin
        gap_cnt <= '0;
        if (both_rise) idx <= '0;
        else begin
          case (idx)
            3'd0:    if (rise_p) idx <= 3'd1;
            3'd1:    idx <= rise_n ? 3'd2 : 3'd0;
            default: begin
              sh  <= {sh[1:0], rise_p};
              idx <= (idx == IDX_END) ? 3'd0 : idx + 3'd1;
            end
          endcase
        end
      end else if (idx != 3'd0) begin
        if (gap_cnt == GAP_LAST) begin
          idx     <= '0;
          gap_cnt <= '0;
        end else begin
          gap_cnt <= gap_cnt + 1'b1;
        end
      end
      if (frm_ok) begin
        sil_cnt <= '0;
        lost    <= 1'b0;
      end else if (!lost) begin
        if (sil_cnt == TMO_LAST) begin
          lost     <= 1'b1;
          lost_evt <= 1'b1;
        end else begin
          sil_cnt <= sil_cnt + 1'b1;
        end
      end
    end
  end

  p_valid_clears_silence_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frm_ok |=> (!lost && sil_cnt == '0));
  p_reject_bad_type_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && new_word[3:2] == MSG_BAD) |=> !frm_ok);

endmodule

// File: rtl/lsl_drive.sv
module lsl_drive
  import lsl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] loc_st,
  input  logic       stuck_det,
  input  logic       frm_ok,
  input  msg_e       frm_type,
  input  logic [1:0] frm_st,
  input  logic       lost,
  input  logic       lost_evt,
  output logic       drv_en,
  output logic       drv_sda,
  output logic       drv_scl,
  output logic       stuck_evt
);

  logic       stk_q, fresh;
  logic [1:0] rem_st;

  // named events
  logic notice_rx, state_rx, drop_evt, rejoin_ok;

  always_comb begin
    stuck_evt = stuck_det && !stk_q;
    notice_rx = frm_ok && (frm_type == MSG_STUCK || frm_type == MSG_NODRV);
    state_rx  = frm_ok && (frm_type == MSG_STATE);
    drop_evt  = lost_evt || notice_rx || stuck_evt;
    rejoin_ok = fresh && (rem_st == 2'b11) && (loc_st == 2'b11) && !stuck_det && !lost;
    drv_sda   = drv_en ? rem_st[1] : 1'b1;
    drv_scl   = drv_en ? rem_st[0] : 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stk_q  <= 1'b0;
      fresh  <= 1'b0;
      rem_st <= 2'b11;
      drv_en <= 1'b0;
    end else begin
      stk_q <= stuck_det;
      if (state_rx) rem_st <= frm_st;
      if (drop_evt) begin
        drv_en <= 1'b0;
        fresh  <= 1'b0;
      end else begin
        if (state_rx) fresh <= 1'b1;
        if (!drv_en && rejoin_ok) drv_en <= 1'b1;
      end
    end
  end

  p_drop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> !drv_en);
  p_rejoin_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_en) |-> ($past(loc_st) == 2'b11 && !$past(stuck_det)));

endmodule

// File: rtl/line_state_link.sv
module line_state_link
  import lsl_pkg::*;
#(
  parameter int unsigned PULSE_CYC   = 9,
  parameter int unsigned GAP_CYC     = 9,
  parameter int unsigned REFRESH_CYC = 287500,
  parameter int unsigned GAP_LIMIT   = 64,
  parameter int unsigned RX_TMO_CYC  = 1150000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic loc_sda,
  input  logic loc_scl,
  input  logic stuck_det,
  input  logic rx_p,
  input  logic rx_n,
  output logic tx_p,
  output logic tx_n,
  output logic drv_en,
  output logic drv_sda,
  output logic drv_scl
);

  logic [1:0] st_q;
  logic       frm_ok, lost, lost_evt, stuck_evt;
  msg_e       frm_type;
  logic [1:0] frm_st;

  lsl_tx #(
    .PULSE_CYC  (PULSE_CYC),
    .GAP_CYC    (GAP_CYC),
    .REFRESH_CYC(REFRESH_CYC)
  ) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_in    ({loc_sda, loc_scl}),
    .stuck_req(stuck_evt),
    .nodrv_req(lost_evt),
    .tx_p     (tx_p),
    .tx_n     (tx_n),
    .st_q     (st_q)
  );

  lsl_rx #(
    .GAP_LIMIT (GAP_LIMIT),
    .RX_TMO_CYC(RX_TMO_CYC)
  ) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_p    (rx_p),
    .rx_n    (rx_n),
    .frm_ok  (frm_ok),
    .frm_type(frm_type),
    .frm_st  (frm_st),
    .lost    (lost),
    .lost_evt(lost_evt)
  );

  lsl_drive u_drv (
    .clk      (clk),
    .rst_n    (rst_n),
    .loc_st   (st_q),
    .stuck_det(stuck_det),
    .frm_ok   (frm_ok),
    .frm_type (frm_type),
    .frm_st   (frm_st),
    .lost     (lost),
    .lost_evt (lost_evt),
    .drv_en   (drv_en),
    .drv_sda  (drv_sda),
    .drv_scl  (drv_scl),
    .stuck_evt(stuck_evt)
  );

endmodule

// File: tb/tb_line_state_link.sv
module tb_line_state_link;

  localparam int PULSE = 3;
  localparam int GAP   = 3;
  localparam int RFSH  = 3000;
  localparam int GLIM  = 20;
  localparam int TMO   = 2000;

  logic clk = 1'b0;
  logic rst_n, loc_sda, loc_scl, stuck_det, rx_p, rx_n;
  logic tx_p, tx_n, drv_en, drv_sda, drv_scl;

  always #2 clk = ~clk;

  line_state_link #(
    .PULSE_CYC(PULSE), .GAP_CYC(GAP), .REFRESH_CYC(RFSH),
    .GAP_LIMIT(GLIM), .RX_TMO_CYC(TMO)
  ) dut (
    .clk(clk), .rst_n(rst_n), .loc_sda(loc_sda), .loc_scl(loc_scl),
    .stuck_det(stuck_det), .rx_p(rx_p), .rx_n(rx_n), .tx_p(tx_p), .tx_n(tx_n),
    .drv_en(drv_en), .drv_sda(drv_sda), .drv_scl(drv_scl)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [3:0] exp_q[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_loc(input logic [1:0] v);
    @(negedge clk);
    loc_sda = v[1];
    loc_scl = v[0];
  endtask

  task automatic pulse(input logic p, input logic n);
    @(negedge clk);
    rx_p = p;
    rx_n = n;
    repeat (PULSE) @(negedge clk);
    rx_p = 1'b0;
    rx_n = 1'b0;
    repeat (GAP - 1) @(negedge clk);
  endtask

  task automatic send_rx(input logic [1:0] kind, input logic [1:0] lvl);
    pulse(1, 0);
    pulse(0, 1);
    pulse(kind[1], !kind[1]);
    pulse(kind[0], !kind[0]);
    pulse(lvl[1], !lvl[1]);
    pulse(lvl[0], !lvl[0]);
  endtask

  function automatic logic [2:0] drv3();
    return {drv_en, drv_sda, drv_scl};
  endfunction

  // monitor: decodes outgoing frames and compares them with the queue
  logic [5:0] m_rail;
  logic       m_fmt;
  int         m_w, m_wait;
  logic [3:0] m_got, m_exp;
  initial begin : monitor
    forever begin
      @(negedge clk);
      if (tx_p || tx_n) begin
        m_fmt = 1'b1;
        for (int s = 0; s < 6; s++) begin
          m_wait = 0;
          while (!(tx_p || tx_n) && m_wait < 40) begin
            @(negedge clk);
            m_wait++;
          end
          m_rail[5 - s] = tx_p;
          m_w = 0;
          while (tx_p || tx_n) begin
            if (tx_p && tx_n) m_fmt = 1'b0;
            m_w++;
            @(negedge clk);
          end
          if (m_w != PULSE) m_fmt = 1'b0;
        end
        if (m_rail[5:4] != 2'b10) m_fmt = 1'b0;
        m_got = m_rail[3:0];
        check(m_fmt, "R2", "frame pulse format", 8'(m_rail), 8'(6'b100000 | m_rail[3:0]));
        if (exp_q.size() == 0) begin
          check(1'b0, "R4", "unexpected frame", 8'(m_got), 8'hff);
        end else begin
          m_exp = exp_q.pop_front();
          check(m_got == m_exp, "R3", "frame payload {type,sda,scl}", 8'(m_got), 8'(m_exp));
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R1", "watchdog expired", 8'h0, 8'h1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 1'b0; loc_sda = 1'b1; loc_scl = 1'b1;
    stuck_det = 1'b0; rx_p = 1'b0; rx_n = 1'b0;
    exp_q.push_back(4'b0011);
    idle(5);
    check(!tx_p && !tx_n, "R1", "rails low in reset", {6'b0, tx_p, tx_n}, 8'h0);
    check(drv3() == 3'b011, "R13", "released in reset", 8'(drv3()), 8'h3);
    rst_n = 1'b1;
    idle(60);
    check(drv3() == 3'b011, "R1", "no driving after reset", 8'(drv3()), 8'h3);

    // R4: event driven updates
    exp_q.push_back(4'b0001); set_loc(2'b01); idle(60);
    exp_q.push_back(4'b0000); set_loc(2'b00); idle(60);

    // R5: changes during a frame collapse into one follow-up with latest levels
    exp_q.push_back(4'b0010); set_loc(2'b10); idle(10);
    set_loc(2'b11); idle(2);
    exp_q.push_back(4'b0001); set_loc(2'b01); idle(100);
    check(exp_q.size() == 0, "R5", "queued follow-up frames", 8'(exp_q.size()), 8'h0);

    // R12: remote quiet but local busy -> no driving
    send_rx(2'b00, 2'b11); idle(5);
    check(drv3() == 3'b011, "R12", "local not quiet blocks rejoin", 8'(drv3()), 8'h3);
    exp_q.push_back(4'b0011); set_loc(2'b11); idle(5);
    check(drv3() == 3'b111, "R12", "rejoin when both quiet", 8'(drv3()), 8'h7);
    idle(60);

    // R7: decoded levels drive the bus
    send_rx(2'b00, 2'b01); idle(3);
    check(drv3() == 3'b101, "R7", "drive levels 01", 8'(drv3()), 8'h5);
    send_rx(2'b00, 2'b10); idle(3);
    check(drv3() == 3'b110, "R7", "drive levels 10", 8'(drv3()), 8'h6);

    // R8: malformed frames ignored
    send_rx(2'b11, 2'b00); idle(30);
    check(drv3() == 3'b110, "R8", "type 11 discarded", 8'(drv3()), 8'h6);
    pulse(0, 1); pulse(1, 0); pulse(0, 1); pulse(0, 1); pulse(0, 1); pulse(0, 1); idle(30);
    check(drv3() == 3'b110, "R8", "reversed start discarded", 8'(drv3()), 8'h6);
    pulse(1, 1); pulse(0, 1); pulse(0, 1); pulse(0, 1); pulse(0, 1); pulse(0, 1); idle(30);
    check(drv3() == 3'b110, "R8", "both rails discarded", 8'(drv3()), 8'h6);
    pulse(1, 0); pulse(0, 1); pulse(0, 1); pulse(0, 1); idle(30);
    check(drv3() == 3'b110, "R8", "truncated frame discarded", 8'(drv3()), 8'h6);
    send_rx(2'b00, 2'b00); idle(3);
    check(drv3() == 3'b100, "R8", "valid frame after truncation", 8'(drv3()), 8'h4);

    // R10: peer notices release the bus, payload not applied
    send_rx(2'b10, 2'b11); idle(3);
    check(drv3() == 3'b011, "R10", "not-driving notice drops", 8'(drv3()), 8'h3);
    send_rx(2'b00, 2'b11); idle(3);
    check(drv3() == 3'b111, "R12", "rejoin after notice", 8'(drv3()), 8'h7);
    send_rx(2'b01, 2'b00); idle(3);
    check(drv3() == 3'b011, "R10", "stuck notice drops", 8'(drv3()), 8'h3);
    send_rx(2'b00, 2'b11); idle(3);
    check(drv3() == 3'b111, "R12", "rejoin after stuck notice", 8'(drv3()), 8'h7);

    // R11: local stuck flag
    exp_q.push_back(4'b0111);
    @(negedge clk); stuck_det = 1'b1;
    idle(3);
    check(drv3() == 3'b011, "R11", "stuck flag drops", 8'(drv3()), 8'h3);
    idle(60);
    send_rx(2'b00, 2'b11); idle(3);
    check(drv3() == 3'b011, "R12", "stuck flag blocks rejoin", 8'(drv3()), 8'h3);
    @(negedge clk); stuck_det = 1'b0;
    idle(3);
    check(drv3() == 3'b111, "R12", "rejoin after stuck clears", 8'(drv3()), 8'h7);

    // R6: keepalive refresh
    exp_q.push_back(4'b0011);
    for (int k = 0; k < 4; k++) begin
      send_rx(2'b00, 2'b11);
      idle(800);
      if (k == 1)
        check(exp_q.size() == 1, "R6", "no early refresh", 8'(exp_q.size()), 8'h1);
    end
    check(exp_q.size() == 0, "R6", "refresh frame sent", 8'(exp_q.size()), 8'h0);

    // R9: silence timeout; invalid frames do not keep the link alive
    exp_q.push_back(4'b1011);
    for (int k = 0; k < 3; k++) begin
      idle(300);
      send_rx(2'b11, 2'b11);
    end
    check(drv3() == 3'b111, "R8", "invalid frames have no effect", 8'(drv3()), 8'h7);
    idle(1000);
    check(drv3() == 3'b011, "R9", "timeout drops driving", 8'(drv3()), 8'h3);
    check(exp_q.size() == 0, "R9", "not-driving notice sent", 8'(exp_q.size()), 8'h0);
    idle(300);
    send_rx(2'b00, 2'b11); idle(3);
    check(drv3() == 3'b111, "R12", "rejoin after timeout", 8'(drv3()), 8'h7);
    idle(40);
    check(exp_q.size() == 0, "R4", "all expected frames seen", 8'(exp_q.size()), 8'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule